// File: doc/BRIEF.md
# Dithered Two-Source Clock Controller

This controller derives three on-chip clocks from two oscillator sources: a crystal oscillator and a digitally controlled oscillator (DCO) that offers eight coarse frequency taps. Everything runs on a fast base clock. Each tap and the crystal are presented to the block as single-cycle tick strobes, one per oscillator cycle. The output clocks are square waves that change level on source ticks.

The DCO output is built one cycle at a time. For each cycle the block picks either the programmed coarse tap or the tap one step higher. A 5-bit fine value sets how many of every 32 DCO cycles use the higher tap. These higher-tap cycles are spread across the 32-slot frame rather than bunched together.

The main clock and the subsystem clock can each run from either source. The auxiliary clock always runs from the crystal. Each output has its own divider. A switch from one source to another is glitch-free:
- the old source keeps running until the output is low;
- the output then stays low for two ticks of the new source;
- after that the new source takes over.

If the crystal stops ticking, a sticky fault is raised and both selectable clocks fall back to the DCO. Software sets up the block through a four-register write/read port.

Top module: `clkgen_top`

## Requirements
- R1: After reset the main clock runs from the DCO with divide-by-1. The fault flag is 0 and both source status bits are 0. The oscillator register reads 0x103 (tap 3, fine value 0, DCO enabled, crystal disabled). The routing register reads 0.
- R2: When the fine value is 0, every DCO cycle comes from the selected tap.
- R3: With fine value m, exactly m of any 32 consecutive DCO cycles come from the tap one above the selected tap. All other DCO cycles come from the selected tap. The oscillator register (address 0) holds the tap in bits [2:0], the fine value in [7:3], DCO enable in bit 8 and crystal enable in bit 9.
- R4: A DCO cycle and the one after it use the higher tap together only when m exceeds 16. For m of 16 or less, no two consecutive DCO cycles use the higher tap.
- R5: With tap 7 selected, every DCO cycle comes from tap 7, whatever the fine value.
- R6: Each output changes level once per N ticks of its source, and only rises on a source tick. N is 1, 2, 4 or 8 for divider codes 0 to 3. The routing register (address 1) holds these codes: main in bits [3:2], subsystem in [5:4], auxiliary in [7:6].
- R7: The auxiliary clock changes level only on crystal ticks. The subsystem clock uses the crystal when routing bit 1 is set; status bit 2 shows this.
- R8: Setting routing bit 0 moves the main clock to the crystal without a shortened phase. Status bit 1 (status register, address 3) then reads 1.
- R9: The fault flag (status bit 0) sets when the crystal is enabled and the count of DCO cycles with no crystal tick reaches the limit register (address 2). The flag stays set until a write with bit 0 = 1 to the status register clears it.
- R10: While the fault flag is set, routing bits 0 and 1 read 0 and the main and subsystem clocks run from the DCO. They stay on the DCO after the flag is cleared.
- R11: Clearing DCO enable stops a DCO-driven main clock. Clearing crystal enable stops the auxiliary clock.
- R12: The limit register resets to the parameter DEF_LIMIT and reads back that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tap_tick_i | input | NTAP | One tick strobe per DCO tap cycle |
| xtal_tick_i | input | 1 | One tick strobe per crystal cycle |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 2 | Register address for write and read |
| cfg_wdata_i | input | 16 | Register write data |
| cfg_rdata_o | output | 16 | Read data for cfg_addr_i |
| mclk_o | output | 1 | Main clock |
| smclk_o | output | 1 | Subsystem clock |
| aclk_o | output | 1 | Auxiliary clock |
| xt_fault_o | output | 1 | Sticky crystal fault flag |
| mclk_on_xt_o | output | 1 | Main clock currently runs from crystal |

## Verification
The bench keeps NTAP=8 and FR_W=5, so the full 32-slot dither frame and the tap-7 ceiling are exercised. It builds the block with LIM_W=8 and DEF_LIMIT=12. With these values the crystal fault is reached about a hundred base cycles after the crystal stops, without writing the limit register. The bench pulses the taps in strict rotation, one tap per base cycle. This lets it tell, from the timing of each main-clock edge, which tap produced that DCO cycle, so the counts of higher-tap cycles and their spread are checked directly.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;

  localparam int DCODE_W = 2;
  localparam int DCNT_W  = 3;
  localparam int REG_W   = 16;

  localparam logic [1:0] A_OSC   = 2'd0;
  localparam logic [1:0] A_ROUTE = 2'd1;
  localparam logic [1:0] A_LIMIT = 2'd2;
  localparam logic [1:0] A_STAT  = 2'd3;

  typedef enum logic [1:0] {
    BR_RUN   = 2'd0,
    BR_DRAIN = 2'd1,
    BR_SYNC  = 2'd2
  } br_state_e;

  // terminal count of a divider: N-1 for N = 1, 2, 4, 8
  function automatic logic [DCNT_W-1:0] div_last(input logic [DCODE_W-1:0] code);
    logic [DCNT_W-1:0] m;
    case (code)
      2'd0:    m = 3'd0;
      2'd1:    m = 3'd1;
      2'd2:    m = 3'd3;
      default: m = 3'd7;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/clkgen_div.sv
module clkgen_div
  import clkgen_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_i,
  input  logic               clr_i,
  input  logic [DCODE_W-1:0] code_i,
  output logic               lvl_o
);

  logic [DCNT_W-1:0] cnt_q, cnt_d;
  logic              lvl_q, lvl_d;

  always_comb begin
    cnt_d = cnt_q;
    lvl_d = lvl_q;
    if (clr_i) begin
      cnt_d = '0;
      lvl_d = 1'b0;
    end else if (tick_i) begin
      if (cnt_q >= div_last(code_i)) begin
        cnt_d = '0;
        lvl_d = ~lvl_q;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      lvl_q <= lvl_d;
    end
  end

  assign lvl_o = lvl_q;

endmodule

// File: rtl/clkgen_dco_mod.sv
module clkgen_dco_mod #(
  parameter  int NTAP  = 8,
  parameter  int FR_W  = 5,
  localparam int SEL_W = $clog2(NTAP)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [NTAP-1:0]  tap_tick_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [FR_W-1:0]  fine_i,
  output logic             dco_tick_o
);

  localparam logic [SEL_W-1:0] TOP_TAP = SEL_W'(NTAP - 1);

  logic [FR_W-1:0]  slot_q, slot_d;
  logic [FR_W-1:0]  slot_rev;
  logic [SEL_W-1:0] use_tap;
  logic             step_up;

  // bit-reversed slot index spreads the raised cycles over the frame
  for (genvar i = 0; i < FR_W; i++) begin : g_rev
    assign slot_rev[i] = slot_q[FR_W-1-i];
  end

  always_comb begin
    step_up = (slot_rev < fine_i);
    if (step_up && (sel_i != TOP_TAP)) begin
      use_tap = sel_i + 1'b1;
    end else begin
      use_tap = sel_i;
    end
    dco_tick_o = en_i & tap_tick_i[use_tap];
    slot_d     = dco_tick_o ? slot_q + 1'b1 : slot_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
    end else begin
      slot_q <= slot_d;
    end
  end

endmodule

// File: rtl/clkgen_branch.sv
module clkgen_branch
  import clkgen_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_dco_i,
  input  logic               tick_xt_i,
  input  logic               want_xt_i,
  input  logic               xt_bad_i,
  input  logic [DCODE_W-1:0] code_i,
  output logic               clk_o,
  output logic               on_xt_o
);

  br_state_e  st_q, st_d;
  logic       src_q, src_d;
  logic       tgt_q, tgt_d;
  logic [1:0] sync_q, sync_d;
  logic       run_tick, div_clr, lvl;
  logic       cur_tick, new_tick;

  assign cur_tick = src_q ? tick_xt_i : tick_dco_i;
  assign new_tick = tgt_q ? tick_xt_i : tick_dco_i;

  always_comb begin
    st_d     = st_q;
    src_d    = src_q;
    tgt_d    = tgt_q;
    sync_d   = sync_q;
    run_tick = 1'b0;
    div_clr  = 1'b0;
    case (st_q)
      BR_RUN: begin
        run_tick = cur_tick;
        if (want_xt_i != src_q) begin
          if (src_q && xt_bad_i) begin
            st_d    = BR_SYNC;
            tgt_d   = want_xt_i;
            sync_d  = '0;
            div_clr = 1'b1;
          end else begin
            st_d = BR_DRAIN;
          end
        end
      end
      BR_DRAIN: begin
        if (want_xt_i == src_q) begin
          st_d     = BR_RUN;
          run_tick = cur_tick;
        end else if ((src_q && xt_bad_i) || !lvl) begin
          st_d    = BR_SYNC;
          tgt_d   = want_xt_i;
          sync_d  = '0;
          div_clr = 1'b1;
        end else begin
          run_tick = cur_tick;
        end
      end
      default: begin
        if (want_xt_i != tgt_q) begin
          tgt_d  = want_xt_i;
          sync_d = '0;
        end else if (new_tick) begin
          if (sync_q == 2'd1) begin
            st_d  = BR_RUN;
            src_d = tgt_q;
          end else begin
            sync_d = sync_q + 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= BR_RUN;
      src_q  <= 1'b0;
      tgt_q  <= 1'b0;
      sync_q <= '0;
    end else begin
      st_q   <= st_d;
      src_q  <= src_d;
      tgt_q  <= tgt_d;
      sync_q <= sync_d;
    end
  end

  clkgen_div u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (run_tick),
    .clr_i  (div_clr),
    .code_i (code_i),
    .lvl_o  (lvl)
  );

  assign clk_o   = lvl;
  assign on_xt_o = src_q;

endmodule

// File: rtl/clkgen_xt_mon.sv
module clkgen_xt_mon #(
  parameter int LIM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xt_en_i,
  input  logic             dco_tick_i,
  input  logic             xt_tick_i,
  input  logic [LIM_W-1:0] limit_i,
  input  logic             clr_i,
  output logic             fault_o
);

  localparam logic [LIM_W-1:0] CNT_MAX = '1;

  logic [LIM_W-1:0] quiet_q, quiet_d;
  logic             fault_q, fault_d;
  logic             trip;

  always_comb begin
    quiet_d = quiet_q;
    if (!xt_en_i || xt_tick_i) begin
      quiet_d = '0;
    end else if (dco_tick_i && (quiet_q != CNT_MAX)) begin
      quiet_d = quiet_q + 1'b1;
    end
    trip    = xt_en_i && (limit_i != '0) && (quiet_q >= limit_i);
    fault_d = trip ? 1'b1 : (clr_i ? 1'b0 : fault_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quiet_q <= '0;
      fault_q <= 1'b0;
    end else begin
      quiet_q <= quiet_d;
      fault_q <= fault_d;
    end
  end

  assign fault_o = fault_q;

endmodule

// File: rtl/clkgen_top.sv
module clkgen_top
  import clkgen_pkg::*;
#(
  parameter  int NTAP      = 8,
  parameter  int FR_W      = 5,
  parameter  int LIM_W     = 16,
  parameter  int DEF_LIMIT = 64,
  localparam int SEL_W     = $clog2(NTAP)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NTAP-1:0]  tap_tick_i,
  input  logic             xtal_tick_i,
  input  logic             cfg_we_i,
  input  logic [1:0]       cfg_addr_i,
  input  logic [REG_W-1:0] cfg_wdata_i,
  output logic [REG_W-1:0] cfg_rdata_o,
  output logic             mclk_o,
  output logic             smclk_o,
  output logic             aclk_o,
  output logic             xt_fault_o,
  output logic             mclk_on_xt_o
);

  localparam int FINE_LO = SEL_W;
  localparam int DEN_BIT = SEL_W + FR_W;
  localparam int XEN_BIT = SEL_W + FR_W + 1;
  localparam logic [SEL_W-1:0] TAP_RST = SEL_W'(3);

  // reset: asserted at once, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_q_n = rst_sync_q[1];

  logic [SEL_W-1:0]   tap_q, tap_d;
  logic [FR_W-1:0]    fine_q, fine_d;
  logic               den_q, den_d, xen_q, xen_d;
  logic               mx_q, mx_d, sx_q, sx_d;
  logic [DCODE_W-1:0] dm_q, dm_d, ds_q, ds_d, da_q, da_d;
  logic [LIM_W-1:0]   lim_q, lim_d;
  logic               fault, fault_clr, xt_bad;
  logic               dco_tick, xt_tick, sub_on_xt;

  assign fault_clr = cfg_we_i && (cfg_addr_i == A_STAT) && cfg_wdata_i[0];
  assign xt_tick   = xtal_tick_i & xen_q;
  assign xt_bad    = fault | ~xen_q;

  always_comb begin
    tap_d  = tap_q;
    fine_d = fine_q;
    den_d  = den_q;
    xen_d  = xen_q;
    mx_d   = mx_q;
    sx_d   = sx_q;
    dm_d   = dm_q;
    ds_d   = ds_q;
    da_d   = da_q;
    lim_d  = lim_q;
    if (cfg_we_i) begin
      case (cfg_addr_i)
        A_OSC: begin
          tap_d  = cfg_wdata_i[SEL_W-1:0];
          fine_d = cfg_wdata_i[FINE_LO +: FR_W];
          den_d  = cfg_wdata_i[DEN_BIT];
          xen_d  = cfg_wdata_i[XEN_BIT];
        end
        A_ROUTE: begin
          mx_d = cfg_wdata_i[0];
          sx_d = cfg_wdata_i[1];
          dm_d = cfg_wdata_i[3:2];
          ds_d = cfg_wdata_i[5:4];
          da_d = cfg_wdata_i[7:6];
        end
        A_LIMIT: lim_d = cfg_wdata_i[LIM_W-1:0];
        default: ;
      endcase
    end
    if (fault) begin
      mx_d = 1'b0;
      sx_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      tap_q  <= TAP_RST;
      fine_q <= '0;
      den_q  <= 1'b1;
      xen_q  <= 1'b0;
      mx_q   <= 1'b0;
      sx_q   <= 1'b0;
      dm_q   <= '0;
      ds_q   <= '0;
      da_q   <= '0;
      lim_q  <= LIM_W'(DEF_LIMIT);
    end else begin
      tap_q  <= tap_d;
      fine_q <= fine_d;
      den_q  <= den_d;
      xen_q  <= xen_d;
      mx_q   <= mx_d;
      sx_q   <= sx_d;
      dm_q   <= dm_d;
      ds_q   <= ds_d;
      da_q   <= da_d;
      lim_q  <= lim_d;
    end
  end

  always_comb begin
    case (cfg_addr_i)
      A_OSC:   cfg_rdata_o = REG_W'({xen_q, den_q, fine_q, tap_q});
      A_ROUTE: cfg_rdata_o = REG_W'({da_q, ds_q, dm_q, sx_q, mx_q});
      A_LIMIT: cfg_rdata_o = REG_W'(lim_q);
      default: cfg_rdata_o = REG_W'({sub_on_xt, mclk_on_xt_o, fault});
    endcase
  end

  clkgen_dco_mod #(.NTAP(NTAP), .FR_W(FR_W)) u_dco (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .en_i       (den_q),
    .tap_tick_i (tap_tick_i),
    .sel_i      (tap_q),
    .fine_i     (fine_q),
    .dco_tick_o (dco_tick)
  );

  clkgen_xt_mon #(.LIM_W(LIM_W)) u_mon (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .xt_en_i    (xen_q),
    .dco_tick_i (dco_tick),
    .xt_tick_i  (xt_tick),
    .limit_i    (lim_q),
    .clr_i      (fault_clr),
    .fault_o    (fault)
  );

  clkgen_branch u_main (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .tick_dco_i (dco_tick),
    .tick_xt_i  (xt_tick),
    .want_xt_i  (mx_q & ~xt_bad),
    .xt_bad_i   (xt_bad),
    .code_i     (dm_q),
    .clk_o      (mclk_o),
    .on_xt_o    (mclk_on_xt_o)
  );

  clkgen_branch u_sub (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .tick_dco_i (dco_tick),
    .tick_xt_i  (xt_tick),
    .want_xt_i  (sx_q & ~xt_bad),
    .xt_bad_i   (xt_bad),
    .code_i     (ds_q),
    .clk_o      (smclk_o),
    .on_xt_o    (sub_on_xt)
  );

  clkgen_div u_aux (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .tick_i (xt_tick),
    .clr_i  (1'b0),
    .code_i (da_q),
    .lvl_o  (aclk_o)
  );

  assign xt_fault_o = fault;

endmodule

// File: rtl/clkgen_chk.sv
module clkgen_chk #(
  parameter int NTAP = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NTAP-1:0] tap_tick_i,
  input logic            xtal_tick_i,
  input logic            cfg_we_i,
  input logic [1:0]      cfg_addr_i,
  input logic [15:0]     cfg_wdata_i,
  input logic            mclk_o,
  input logic            smclk_o,
  input logic            aclk_o,
  input logic            xt_fault_o,
  input logic            mclk_on_xt_o
);

  logic clr_wr;
  assign clr_wr = cfg_we_i && (cfg_addr_i == 2'd3) && cfg_wdata_i[0];

  a_r7_aux_from_crystal: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(aclk_o) |-> $past(xtal_tick_i));

  a_r6_mclk_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mclk_o) |-> $past(xtal_tick_i || (|tap_tick_i)));

  a_r6_smclk_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(smclk_o) |-> $past(xtal_tick_i || (|tap_tick_i)));

  a_r9_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (xt_fault_o && !clr_wr) |=> xt_fault_o);

  a_r10_no_xt_after_fault: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mclk_on_xt_o) |-> !$past(xt_fault_o));

endmodule

bind clkgen_top clkgen_chk #(.NTAP(NTAP)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tap_tick_i   (tap_tick_i),
  .xtal_tick_i  (xtal_tick_i),
  .cfg_we_i     (cfg_we_i),
  .cfg_addr_i   (cfg_addr_i),
  .cfg_wdata_i  (cfg_wdata_i),
  .mclk_o       (mclk_o),
  .smclk_o      (smclk_o),
  .aclk_o       (aclk_o),
  .xt_fault_o   (xt_fault_o),
  .mclk_on_xt_o (mclk_on_xt_o)
);

// File: tb/tb_clkgen_top.sv
`timescale 1ns/1ps
module tb_clkgen_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  tap_tick_i;
  logic        xtal_tick_i;
  logic        cfg_we_i;
  logic [1:0]  cfg_addr_i;
  logic [15:0] cfg_wdata_i;
  logic [15:0] cfg_rdata_o;
  logic        mclk_o, smclk_o, aclk_o, xt_fault_o, mclk_on_xt_o;

  always #2.5 clk = ~clk;

  clkgen_top #(.NTAP(8), .FR_W(5), .LIM_W(8), .DEF_LIMIT(12)) dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .tap_tick_i   (tap_tick_i),
    .xtal_tick_i  (xtal_tick_i),
    .cfg_we_i     (cfg_we_i),
    .cfg_addr_i   (cfg_addr_i),
    .cfg_wdata_i  (cfg_wdata_i),
    .cfg_rdata_o  (cfg_rdata_o),
    .mclk_o       (mclk_o),
    .smclk_o      (smclk_o),
    .aclk_o       (aclk_o),
    .xt_fault_o   (xt_fault_o),
    .mclk_on_xt_o (mclk_on_xt_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit taps_on = 1'b1;
  bit xt_run = 1'b0;
  int drv_tap = 8;
  bit clr_req = 1'b0;

  logic m_prev = 1'b0, s_prev = 1'b0, a_prev = 1'b0;
  int m_last, s_last, a_last, m_iv, s_iv, a_iv, m_cnt, s_cnt, a_cnt, m_min;
  bit m_fresh, s_fresh, a_fresh;
  int hist [0:63];
  int hidx;

  // monitor, then drive the oscillator ticks for the coming cycle
  always @(negedge clk) begin
    if (clr_req) begin
      m_fresh = 1; s_fresh = 1; a_fresh = 1;
      m_iv = 0; s_iv = 0; a_iv = 0; m_min = 1000; hidx = 0;
      clr_req = 0;
    end
    if (mclk_o !== m_prev) begin
      m_prev = mclk_o; m_cnt++;
      if (!m_fresh) begin
        m_iv = cyc - m_last;
        if (m_iv < m_min) m_min = m_iv;
      end
      m_fresh = 0; m_last = cyc;
      if (hidx < 64) begin hist[hidx] = drv_tap; hidx++; end
    end
    if (smclk_o !== s_prev) begin
      s_prev = smclk_o; s_cnt++;
      if (!s_fresh) s_iv = cyc - s_last;
      s_fresh = 0; s_last = cyc;
    end
    if (aclk_o !== a_prev) begin
      a_prev = aclk_o; a_cnt++;
      if (!a_fresh) a_iv = cyc - a_last;
      a_fresh = 0; a_last = cyc;
    end
    cyc++;
    drv_tap     = taps_on ? (cyc % 8) : 8;
    tap_tick_i  = taps_on ? 8'(1 << (cyc % 8)) : 8'h00;
    xtal_tick_i = xt_run && ((cyc % 5) == 0);
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic stats_clr();
    @(posedge clk);
    clr_req = 1'b1;
    @(posedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
    @(negedge clk);
    cfg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    @(negedge clk);
    cfg_addr_i = a;
    #1;
    v = int'(cfg_rdata_o);
  endtask

  task automatic t_reset();
    int v;
    chk("R1 fault after reset", int'(xt_fault_o), 0);
    chk("R1 main on crystal after reset", int'(mclk_on_xt_o), 0);
    rd(2'd0, v); chk("R1 oscillator register", v, 'h103);
    rd(2'd1, v); chk("R1 routing register", v, 0);
    rd(2'd3, v); chk("R1 status register", v, 0);
    rd(2'd2, v); chk("R12 limit register", v, 12);
    stats_clr(); wait_cyc(100);
    chk("R1 main clock period from DCO tap", m_iv, 8);
  endtask

  // sel / fine dither check, R2 R3 R4 R5
  task automatic t_dither(input int sel, input int fine, input string tag);
    int hi, lo, other, pairs;
    wr(2'd0, 16'(sel | (fine << 3) | (1 << 8)));
    stats_clr(); wait_cyc(400);
    hi = 0; lo = 0; other = 0; pairs = 0;
    for (int i = 2; i < 34; i++) begin
      if (sel < 7 && hist[i] == sel + 1) hi++;
      else if (hist[i] == sel) lo++;
      else other++;
      if (sel < 7 && hist[i] == sel + 1 && hist[i+1] == sel + 1) pairs++;
    end
    chk({tag, " raised DCO cycles per frame"}, hi, (sel == 7) ? 0 : fine);
    chk({tag, " cycles from other taps"}, other, 0);
    if (fine <= 16) chk({tag, " R4 adjacent raised cycles"}, pairs, 0);
  endtask

  task automatic t_div();
    wr(2'd0, 16'h100);
    wr(2'd1, 16'((2 << 2) | (1 << 4)));
    stats_clr(); wait_cyc(200);
    chk("R6 main divide by 4", m_iv, 32);
    chk("R6 sub divide by 2", s_iv, 16);
  endtask

  task automatic t_aux();
    int v;
    xt_run = 1'b1;
    wr(2'd0, 16'h300);
    wr(2'd1, 16'((3 << 6) | 2));
    stats_clr(); wait_cyc(300);
    chk("R7 aux divide by 8 from crystal", a_iv, 40);
    chk("R7 sub from crystal", s_iv, 5);
    rd(2'd3, v); chk("R7 sub on crystal status", (v >> 2) & 1, 1);
  endtask

  task automatic t_switch();
    int v;
    wr(2'd1, 16'((3 << 6) | 3));
    stats_clr(); wait_cyc(200);
    rd(2'd3, v); chk("R8 main on crystal status", (v >> 1) & 1, 1);
    chk("R8 main period from crystal", m_iv, 5);
    chk("R8 no shortened phase during switch", int'(m_min >= 5), 1);
  endtask

  task automatic t_fault();
    int v;
    xt_run = 1'b0;
    stats_clr(); wait_cyc(250);
    chk("R9 fault raised on silent crystal", int'(xt_fault_o), 1);
    rd(2'd3, v); chk("R10 main back on DCO", (v >> 1) & 1, 0);
    chk("R10 sub back on DCO", (v >> 2) & 1, 0);
    rd(2'd1, v); chk("R10 routing selects cleared", v & 3, 0);
    chk("R10 main period from DCO", m_iv, 8);
    xt_run = 1'b1;
    wait_cyc(100);
    chk("R9 fault stays set with crystal back", int'(xt_fault_o), 1);
    wr(2'd3, 16'h0001);
    wait_cyc(2);
    chk("R9 fault cleared by write", int'(xt_fault_o), 0);
    wait_cyc(60);
    chk("R10 main stays on DCO after clear", int'(mclk_on_xt_o), 0);
  endtask

  task automatic t_enable();
    int c;
    wr(2'd0, 16'h200);
    wait_cyc(20);
    c = m_cnt;
    wait_cyc(100);
    chk("R11 main stops with DCO disabled", m_cnt - c, 0);
    wr(2'd0, 16'h100);
    wait_cyc(20);
    c = a_cnt;
    wait_cyc(100);
    chk("R11 aux stops with crystal disabled", a_cnt - c, 0);
  endtask

  bit done = 1'b0;

  initial begin
    rst_n = 1'b0;
    cfg_we_i = 1'b0; cfg_addr_i = '0; cfg_wdata_i = '0;
    tap_tick_i = '0; xtal_tick_i = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_dither(5, 0, "R2 fine 0");
    t_dither(2, 5, "R3 fine 5");
    t_dither(1, 16, "R3 fine 16");
    t_dither(0, 31, "R3 fine 31");
    t_dither(7, 20, "R5 tap 7");
    t_div();
    t_aux();
    t_switch();
    t_fault();
    t_enable();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule